// File: doc/BRIEF.md
# SDRAM Row Boundary Decoder

This block maps a 32-bit physical address onto one of four SDRAM chip-select rows. Software programs four 8-bit limit registers. Each register holds the cumulative top of its row, in 16 MB steps, so a limit value is compared against address bits 31:24. Row 0 begins at address zero. Every later row begins where the row below it ends. A row whose limit is the same as its lower neighbour's holds no memory and is never selected.

A requester presents an address together with a valid strobe. The block answers in the next cycle with four outputs:

- a one-hot chip-select,
- the row number,
- a hit flag,
- an out-of-range flag for addresses at or beyond the top row's limit.

A small write and read port gives software access to the four limit registers. Populated rows may have different sizes, from 16 MB up to 512 MB each.

Top module: `row_limit_decoder`

## Requirements
- R1: When `cfgWrEn` is high at a clock edge, `cfgWrData` is stored into limit register `cfgAddr` (0 to 3). `cfgRdData` always shows the register selected by `cfgAddr`. A limit register changes only on such a write.
- R2: Reset clears all four limit registers to 0, so every row is empty. It also clears `respValid`, `hit`, `outOfRange`, `rowIdx` and `rowSel`. A request made after reset and before any write reports `outOfRange`=1.
- R3: The result of a request sampled with `reqValid`=1 at clock edge k appears after edge k, and `respValid`=1 during that cycle. After an edge with `reqValid`=0, `respValid`, `hit`, `outOfRange`, `rowIdx` and `rowSel` are all 0.
- R4: Let H be `reqAddr[31:24]`. Row n matches when lower(n) <= H < limit(n), where lower(0)=0 and lower(n)=limit(n-1). For the selected row n, `rowSel` has only bit n set, `rowIdx`=n and `hit`=1.
- R5: A row whose limit equals the limit of the row below it (for row 0, a limit of 0) is never selected. Addresses above it go to the next populated row.
- R6: When H >= limit(3), the result has `outOfRange`=1, `hit`=0, `rowSel`=0 and `rowIdx`=0, even if some row would otherwise match.
- R7: When the limits are not non-decreasing, so that several rows match, the lowest-numbered matching row is selected.
- R8: A request sampled at the same edge as a limit write is decoded with the limits as they were before that write.
- R9: `rowSel` never has more than one bit set, and `hit` is 1 exactly when `rowSel` is nonzero.
- R10: Address bits 23:0 have no effect on the result, so the decode granularity is 16 MB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Decode request strobe |
| reqAddr | input | 32 | Physical address to decode |
| cfgWrEn | input | 1 | Limit register write enable |
| cfgAddr | input | 2 | Limit register index for write and read |
| cfgWrData | input | 8 | Limit value to write (16 MB units) |
| cfgRdData | output | 8 | Contents of the limit register at `cfgAddr` |
| respValid | output | 1 | Result valid, one cycle after `reqValid` |
| rowSel | output | 4 | One-hot chip-select |
| rowIdx | output | 2 | Index of the selected row |
| hit | output | 1 | The address fell inside a populated row |
| outOfRange | output | 1 | The address is at or above the top row's limit |

## Verification
Every decode result is registered once, so it is due exactly one clock after the edge that samples `reqValid`, and it is cleared at the edge after that. Limit writes become visible on `cfgRdData` one edge after they are presented. The bench drives all inputs on the falling edge. It then samples on the following falling edge, which falls after the single capturing rising edge. A further falling-edge sample confirms that the result has cleared one cycle later.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;
  // Strobes from the control side into the datapath
  typedef struct packed {
    logic capture;   // latch a decode result this edge
    logic cfgWr;     // write a limit register this edge
  } rowdec_strb_t;
endpackage

// File: rtl/rowdec_ctrl.sv
module rowdec_ctrl
  import rowdec_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         cfgWrEn,
  output rowdec_strb_t strb,
  output logic         respValid
);

  always_comb begin
    strb.capture = reqValid;
    strb.cfgWr   = cfgWrEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) respValid <= 1'b0;
    else        respValid <= reqValid;
  end

  p_resp_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> respValid);
  p_idle_after_noreq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !respValid);

endmodule

// File: rtl/rowdec_datapath.sv
module rowdec_datapath
  import rowdec_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int LIM_W = 8,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rowdec_strb_t     strb,
  input  logic [LIM_W-1:0] addrHi,
  input  logic [IDX_W-1:0] cfgAddr,
  input  logic [LIM_W-1:0] cfgWrData,
  output logic [LIM_W-1:0] cfgRdData,
  output logic [ROWS-1:0]  rowSel,
  output logic [IDX_W-1:0] rowIdx,
  output logic             hit,
  output logic             outOfRange
);

  logic [LIM_W-1:0] limitQ [ROWS];
  logic [LIM_W-1:0] lowerB [ROWS];
  logic [ROWS-1:0]  matchVec;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        limitQ[g] <= '0;
      else if (strb.cfgWr && (cfgAddr == IDX_W'(g)))
        limitQ[g] <= cfgWrData;
    end

    if (g == 0) begin : g_base
      assign lowerB[g] = '0;
    end else begin : g_chain
      assign lowerB[g] = limitQ[g-1];
    end

    // An empty row (limit == lower bound) can never satisfy both terms
    assign matchVec[g] = (addrHi >= lowerB[g]) && (addrHi < limitQ[g]);

    p_limit_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(strb.cfgWr) |-> $stable(limitQ[g]));
  end

  assign cfgRdData = limitQ[cfgAddr];

  logic             beyondTop;
  logic             anyMatch;
  logic [IDX_W-1:0] pickIdx;

  assign beyondTop = (addrHi >= limitQ[ROWS-1]);

  // Lowest index wins: scan from the top so lower rows overwrite
  always_comb begin
    anyMatch = 1'b0;
    pickIdx  = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch = 1'b1;
        pickIdx  = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !strb.capture) begin
      rowSel     <= '0;
      rowIdx     <= '0;
      hit        <= 1'b0;
      outOfRange <= 1'b0;
    end else begin
      outOfRange <= beyondTop;
      hit        <= anyMatch && !beyondTop;
      rowIdx     <= (anyMatch && !beyondTop) ? pickIdx : '0;
      rowSel     <= (anyMatch && !beyondTop) ? (ROWS'(1) << pickIdx) : '0;
    end
  end

  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rowSel));
  p_hit_matches_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit == (rowSel != '0));
  p_hit_idx_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> rowSel[rowIdx]);
  p_oor_no_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outOfRange |-> (!hit && rowSel == '0 && rowIdx == '0));

endmodule

// File: rtl/row_limit_decoder.sv
module row_limit_decoder
  import rowdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROWS   = 4,
  parameter int LIM_W  = 8,
  localparam int IDX_W  = $clog2(ROWS),
  localparam int HI_LSB = ADDR_W - LIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgAddr,
  input  logic [LIM_W-1:0]  cfgWrData,
  output logic [LIM_W-1:0]  cfgRdData,
  output logic              respValid,
  output logic [ROWS-1:0]   rowSel,
  output logic [IDX_W-1:0]  rowIdx,
  output logic              hit,
  output logic              outOfRange
);

  rowdec_strb_t strb;
  logic         unusedLowBits;

  // Sub-granule bits never take part in the decode
  assign unusedLowBits = ^reqAddr[HI_LSB-1:0];

  rowdec_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .cfgWrEn   (cfgWrEn),
    .strb      (strb),
    .respValid (respValid)
  );

  rowdec_datapath #(
    .ROWS  (ROWS),
    .LIM_W (LIM_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .addrHi     (reqAddr[ADDR_W-1:HI_LSB]),
    .cfgAddr    (cfgAddr),
    .cfgWrData  (cfgWrData),
    .cfgRdData  (cfgRdData),
    .rowSel     (rowSel),
    .rowIdx     (rowIdx),
    .hit        (hit),
    .outOfRange (outOfRange)
  );

endmodule

// File: tb/tb_row_limit_decoder.sv
`timescale 1ns/1ps
module tb_row_limit_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic        respValid;
  logic [3:0]  rowSel;
  logic [1:0]  rowIdx;
  logic        hit;
  logic        outOfRange;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  row_limit_decoder dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .respValid(respValid), .rowSel(rowSel),
    .rowIdx(rowIdx), .hit(hit), .outOfRange(outOfRange)
  );

  // Vector: {addr[31:0], expHit, expIdx[1:0], expOor}
  // Limits for this table: row0=2, row1=4, row2=4 (empty), row3=12
  localparam int NVEC = 8;
  localparam logic [35:0] VEC [NVEC] = '{
    {32'h0000_0000, 1'b1, 2'd0, 1'b0},
    {32'h01FF_FFFF, 1'b1, 2'd0, 1'b0},
    {32'h0200_0000, 1'b1, 2'd1, 1'b0},
    {32'h03AB_CDEF, 1'b1, 2'd1, 1'b0},
    {32'h0400_0000, 1'b1, 2'd3, 1'b0},
    {32'h0BFF_FFFF, 1'b1, 2'd3, 1'b0},
    {32'h0C00_0000, 1'b0, 2'd0, 1'b1},
    {32'hFFFF_FFFF, 1'b0, 2'd0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {respValid, hit, outOfRange, rowIdx, rowSel}
  function automatic logic [31:0] expBundle(input logic v, input logic h,
                                            input logic [1:0] idx, input logic o);
    logic [3:0] sel;
    sel = h ? (4'b0001 << idx) : 4'b0000;
    return {23'd0, v, h, o, idx, sel};
  endfunction

  function automatic logic [31:0] actBundle();
    return {23'd0, respValid, hit, outOfRange, rowIdx, rowSel};
  endfunction

  task automatic cfgWrite(input logic [1:0] idx, input logic [7:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = idx; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic request(input logic [31:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(8ns * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state of limits and outputs
    for (int i = 0; i < 4; i++) begin
      cfgAddr = 2'(i);
      #1;
      chk("R2 limit reset", 32'(cfgRdData), 32'h0);
    end
    chk("R2 outputs reset", actBundle(), 32'h0);
    request(32'h0000_0000);
    chk("R2 empty map out of range", actBundle(), expBundle(1, 0, 0, 1));

    // R1: program and read back
    cfgWrite(0, 8'h02); cfgWrite(1, 8'h04); cfgWrite(2, 8'h04); cfgWrite(3, 8'h0C);
    cfgAddr = 2'd0; #1; chk("R1 readback row0", 32'(cfgRdData), 32'h02);
    cfgAddr = 2'd3; #1; chk("R1 readback row3", 32'(cfgRdData), 32'h0C);

    // R4 R5 R6 R10: table walk
    for (int v = 0; v < NVEC; v++) begin
      request(VEC[v][35:4]);
      chk($sformatf("R4/R5/R6/R10 vec %0d", v), actBundle(),
          expBundle(1, VEC[v][3], VEC[v][2:1], VEC[v][0]));
    end

    // R3: result clears the cycle after
    request(32'h0200_0000);
    chk("R3 result due", actBundle(), expBundle(1, 1, 1, 0));
    @(negedge clk);
    chk("R3 cleared without request", actBundle(), 32'h0);

    // R5: empty row 2 never selected, even at its boundary value
    request(32'h0400_0000);
    chk("R5 empty row skipped", 32'(rowSel[2]), 32'h0);

    // R7: non-monotonic limits 8,4,12,12
    cfgWrite(0, 8'h08); cfgWrite(1, 8'h04); cfgWrite(2, 8'h0C); cfgWrite(3, 8'h0C);
    request(32'h0500_0000);
    chk("R7 lowest row wins", actBundle(), expBundle(1, 1, 0, 0));
    request(32'h0A00_0000);
    chk("R7 only row2 matches", actBundle(), expBundle(1, 1, 2, 0));

    // R6: out-of-range overrides a match (row0 limit raised above row3)
    cfgWrite(0, 8'h10);
    request(32'h0D00_0000);
    chk("R6 oor overrides match", actBundle(), expBundle(1, 0, 0, 1));
    cfgWrite(0, 8'h08);

    // R8: request in the same cycle as a write sees old limits
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 2'd0; cfgWrData = 8'h0B;
    reqValid = 1'b1; reqAddr = 32'h0900_0000;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    chk("R8 old limits used", actBundle(), expBundle(1, 1, 2, 0));
    #1; chk("R8 write landed", 32'(cfgRdData), 32'h0B);
    request(32'h0900_0000);
    chk("R8 new limits next request", actBundle(), expBundle(1, 1, 0, 0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule